// File: doc/BRIEF.md
# Segment Key Protection Evaluator

This block works out the access rights for one memory reference in a 32-bit MMU that uses segments and hashed pages. It takes the segment register selected for the reference, the privilege of the requester, the 2-bit page-protection code of the page-table entry that matched, and the kind of access requested. It returns the read, write and execute rights, a fault flag for the requested access, and the fields decoded from the segment register, including the virtual segment identifier. The table walk, the translation cache and the delivery of exceptions are handled by other blocks.

The rights come from a small combinational path: segment decode, key selection, a lookup on the protection code, and a compare against the request. A one-cycle output register follows it. A two-state controller runs that register. `ST_IDLE` means no result is being presented. `ST_EMIT` means a result captured on the previous edge is on the outputs. The controller moves `ST_IDLE -> ST_EMIT` and stays in `ST_EMIT` while `in_valid` is high, and moves `ST_EMIT -> ST_IDLE` and stays in `ST_IDLE` while it is low. Result registers load only on a valid cycle and otherwise keep their value.

Top module: `segkey_eval`

## Requirements
- R1: The segment register is decoded with bit 31 as the direct-store flag, bit 30 as the supervisor key, bit 29 as the user key, bit 28 as no-execute, and bits 23..0 as the 24-bit segment identifier, which is presented on `vsid`.
- R2: The key used for the lookup is bit 29 when `user_mode` is 1 and bit 30 when `user_mode` is 0.
- R3: With key 1, protection code 00 grants neither read nor write, codes 01 and 11 grant read only, and code 10 grants read and write.
- R4: With key 0, protection codes 00, 01 and 10 grant read and write, and code 11 grants read only.
- R5: Execute is granted, whatever the key and protection code, unless the no-execute bit is 1, in which case it is denied.
- R6: When the direct-store flag is 1, `direct_store` is 1, no read, write or execute right is granted, and `fault` is 1.
- R7: The `access` encoding is 00 read, 01 write, 10 execute, and 11 reserved. `fault` is 1 when the requested right is not granted, and is always 1 for code 11.
- R8: Inputs sampled on a clock edge with `in_valid` high appear on the outputs after that edge. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high.
- R9: In a cycle with `in_valid` low, the input values have no effect: every result output keeps its previous value.
- R10: During reset and after it, `out_valid`, all rights, `fault`, `direct_store` and `vsid` are 0 until the first valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| seg_reg | input | 32 | Segment register value |
| user_mode | input | 1 | 1 for a user-mode access, 0 for supervisor |
| pp | input | 2 | Page-protection code from the matched entry |
| access | input | 2 | Requested access: 00 read, 01 write, 10 execute, 11 reserved |
| out_valid | output | 1 | Result present |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| fault | output | 1 | Requested access is not granted |
| direct_store | output | 1 | Segment is a direct-store segment |
| vsid | output | 24 | Decoded segment identifier |

## Verification
The bench sets the user key and the supervisor key to opposite values so that each key must be read from the right bit. A design that swapped bits 29 and 30 would then return the rights of the other key. It walks all four protection codes under both keys, which catches a wrong table row such as code 11 giving read/write with key 1. It also gives code 00 with key 1 and no-execute clear, where execute must still be granted even though read and write are not. It sets the direct-store flag on segments whose keys and codes would otherwise grant full rights, so a design that ignored that flag would leak permissions. It also sends the reserved access code, and drives changing inputs while `in_valid` is low; a register that loaded on every cycle would show the new values.

// File: rtl/segkey_pkg.sv
package segkey_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

endpackage

// File: rtl/segkey_decode.sv
module segkey_decode #(
    parameter int SEG_W  = 32,
    parameter int VSID_W = 24
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic              user_mode,
    output logic              ds,
    output logic              nx,
    output logic              key,
    output logic [VSID_W-1:0] vsid
);
    localparam int T_POS  = SEG_W - 1;
    localparam int KS_POS = SEG_W - 2;
    localparam int KP_POS = SEG_W - 3;
    localparam int NX_POS = SEG_W - 4;

    logic unused_mid;

    always_comb begin
        ds   = seg[T_POS];
        nx   = seg[NX_POS];
        // R2: privilege picks which key bit applies
        key  = user_mode ? seg[KP_POS] : seg[KS_POS];
        vsid = seg[VSID_W-1:0];
        unused_mid = ^seg[NX_POS-1:VSID_W];
    end
endmodule

// File: rtl/segkey_rights.sv
module segkey_rights
    import segkey_pkg::*;
#(
    parameter int PP_W = 2
) (
    input  logic            key,
    input  logic [PP_W-1:0] pp,
    input  logic            nx,
    input  logic            ds,
    output rights_t         rights
);
    logic rd_ok, wr_ok;

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        if (key) begin
            unique case (pp)
                2'b00:   begin rd_ok = 1'b0; wr_ok = 1'b0; end
                2'b10:   begin rd_ok = 1'b1; wr_ok = 1'b1; end
                default: begin rd_ok = 1'b1; wr_ok = 1'b0; end
            endcase
        end else begin
            unique case (pp)
                2'b11:   begin rd_ok = 1'b1; wr_ok = 1'b0; end
                default: begin rd_ok = 1'b1; wr_ok = 1'b1; end
            endcase
        end
        rights.rd = rd_ok & ~ds;
        rights.wr = wr_ok & ~ds;
        rights.ex = ~nx & ~ds;
    end

    // R3/R4: no table row grants write without read
    always_comb begin
        p_table_wr_rd_r4: assert (!(wr_ok && !rd_ok));
    end
endmodule

// File: rtl/segkey_fault.sv
module segkey_fault
    import segkey_pkg::*;
(
    input  rights_t rights,
    input  acc_e    acc,
    output logic    fault
);
    always_comb begin
        unique case (acc)
            ACC_READ:  fault = ~rights.rd;
            ACC_WRITE: fault = ~rights.wr;
            ACC_EXEC:  fault = ~rights.ex;
            ACC_RSVD:  fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/segkey_eval.sv
module segkey_eval
    import segkey_pkg::*;
#(
    parameter int SEG_W  = 32,
    parameter int VSID_W = 24,
    parameter int PP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEG_W-1:0]  seg_reg,
    input  logic              user_mode,
    input  logic [PP_W-1:0]   pp,
    input  logic [1:0]        access,
    output logic              out_valid,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic              fault,
    output logic              direct_store,
    output logic [VSID_W-1:0] vsid
);
    localparam int NX_POS = SEG_W - 4;
    localparam int T_POS  = SEG_W - 1;

    logic              ds_c, nx_c, key_c, fault_c;
    logic [VSID_W-1:0] vsid_c;
    rights_t           rights_c;
    emit_state_e       state_q, state_d;

    segkey_decode #(.SEG_W(SEG_W), .VSID_W(VSID_W)) u_decode (
        .seg(seg_reg), .user_mode(user_mode),
        .ds(ds_c), .nx(nx_c), .key(key_c), .vsid(vsid_c)
    );

    segkey_rights #(.PP_W(PP_W)) u_rights (
        .key(key_c), .pp(pp), .nx(nx_c), .ds(ds_c), .rights(rights_c)
    );

    segkey_fault u_fault (
        .rights(rights_c), .acc(acc_e'(access)), .fault(fault_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_r       <= 1'b0;
            perm_w       <= 1'b0;
            perm_x       <= 1'b0;
            fault        <= 1'b0;
            direct_store <= 1'b0;
            vsid         <= '0;
        end else if (in_valid) begin
            perm_r       <= rights_c.rd;
            perm_w       <= rights_c.wr;
            perm_x       <= rights_c.ex;
            fault        <= fault_c;
            direct_store <= ds_c;
            vsid         <= vsid_c;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(perm_r) && $stable(perm_w) && $stable(perm_x)
                       && $stable(fault) && $stable(vsid) && $stable(direct_store)));
    p_ds_noperm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_reg[T_POS]) |=> (direct_store && fault && !perm_r && !perm_w && !perm_x));
    p_nx_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_reg[NX_POS]) |=> !perm_x);
    p_rsvd_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && access == 2'b11) |=> fault);
endmodule

// File: tb/test_segkey_eval.sv
module test_segkey_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] seg_reg = '0;
    logic        user_mode = 1'b0;
    logic [1:0]  pp = '0;
    logic [1:0]  access = '0;
    logic        out_valid, perm_r, perm_w, perm_x, fault, direct_store;
    logic [23:0] vsid;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    segkey_eval i_segkey_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_reg(seg_reg),
        .user_mode(user_mode), .pp(pp), .access(access),
        .out_valid(out_valid), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
        .fault(fault), .direct_store(direct_store), .vsid(vsid)
    );

    // packed {ov, r, w, x, f, ds, vsid}
    function automatic logic [29:0] model(input logic [31:0] s, input logic um,
                                          input logic [1:0] p, input logic [1:0] a);
        logic k, r, w, x, f, ds;
        ds = s[31];
        k  = um ? s[29] : s[30];
        if (k) begin r = (p != 2'b00); w = (p == 2'b10); end
        else   begin r = 1'b1;         w = (p != 2'b11); end
        x = ~s[28];
        if (ds) begin r = 0; w = 0; x = 0; end
        case (a)
            2'b00: f = ~r;
            2'b01: f = ~w;
            2'b10: f = ~x;
            default: f = 1'b1;
        endcase
        return {1'b1, r, w, x, f, ds, s[23:0]};
    endfunction

    task automatic check(input string tag, input logic [29:0] exp);
        logic [29:0] act;
        act = {out_valid, perm_r, perm_w, perm_x, fault, direct_store, vsid};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [29:0] last_exp;

    // drive at negedge, check at the following negedge
    task automatic apply(input string tag, input logic [31:0] s, input logic um,
                         input logic [1:0] p, input logic [1:0] a);
        seg_reg = s; user_mode = um; pp = p; access = a; in_valid = 1'b1;
        @(negedge clk);
        last_exp = model(s, um, p, a);
        check(tag, last_exp);
    endtask

    task automatic idle_probe(input string tag);
        in_valid = 1'b0;
        seg_reg = ~seg_reg; user_mode = ~user_mode; pp = ~pp; access = ~access;
        @(negedge clk);
        check(tag, {1'b0, last_exp[28:0]});
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R10 reset", 30'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 30'd0);

        // R2: keys differ, so the wrong bit shows
        apply("R2 user key1 pp00 write", 32'h2012_3456, 1'b1, 2'b00, 2'b01);
        apply("R2 super key0 pp00 write", 32'h2012_3456, 1'b0, 2'b00, 2'b01);
        apply("R2 super key1 pp00 read", 32'h4000_0001, 1'b0, 2'b00, 2'b00);
        apply("R2 user key0 pp00 read", 32'h4000_0001, 1'b1, 2'b00, 2'b00);
        // R3 / R4 table walk
        for (int p = 0; p < 4; p++) begin
            apply("R3 key1 write", 32'h60AB_CDEF, 1'b1, p[1:0], 2'b01);
            apply("R3 key1 read",  32'h60AB_CDEF, 1'b0, p[1:0], 2'b00);
            apply("R4 key0 write", 32'h0055_AA55, 1'b1, p[1:0], 2'b01);
            apply("R4 key0 read",  32'h0055_AA55, 1'b0, p[1:0], 2'b00);
        end
        // R5: execute with no read/write, and execute denied by NX
        apply("R5 exec no rw", 32'h6000_0000, 1'b1, 2'b00, 2'b10);
        apply("R5 nx deny",    32'h1000_0007, 1'b0, 2'b10, 2'b10);
        // R6: direct-store segment with otherwise full rights
        apply("R6 direct store", 32'h80FF_FFFF, 1'b0, 2'b10, 2'b00);
        apply("R6 direct store exec", 32'h8000_1234, 1'b1, 2'b01, 2'b10);
        // R7 reserved code
        apply("R7 reserved", 32'h0000_0000, 1'b0, 2'b10, 2'b11);
        // R1 field decode with noise in the unused bits
        apply("R1 vsid decode", 32'h0FA5_5A5A, 1'b0, 2'b00, 2'b00);
        // R9 hold, R8 out_valid drop
        idle_probe("R9 hold idle");
        idle_probe("R8 R9 hold second idle");
        apply("R8 resume", 32'h1234_5678, 1'b1, 2'b11, 2'b10);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] s;
            s = $urandom;
            apply("R1 R3 R4 R7 random", s, 1'($urandom), 2'($urandom), 2'($urandom));
            if ($urandom_range(0, 5) == 0) idle_probe("R9 random idle");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule